// File: doc/BRIEF.md
# Gate Clamp Latch Controller

This block decides when the auxiliary clamp switch on a power-transistor gate is closed. The clamp is a second low-impedance path that pulls the gate toward the negative output rail, alongside the normal turn-off path. A comparator outside the block reports when the sensed gate voltage is below the clamp threshold (about 2 V above the negative supply). The block brings that comparator output into its clock domain. During each off period of the drive command it closes the clamp once the gate has fallen past the threshold.

The clamp is latched for each off period. It is open when the command turns off. It closes on the first synchronized report that the gate is below threshold, and it stays closed even if the gate later rises back above the threshold. It opens again only when the command returns high. A disable input holds the clamp open permanently. This input is for boards where the clamp is not used and the sense pin is tied low.

Top module: `mc_clamp_ctrl`

## Requirements
- R1: While reset is asserted and after reset is released, `clamp_en` is 0 until a below-threshold report arrives during an off period.
- R2: `clamp_en` is 0 in every cycle in which `drive_cmd` is 1, whatever the value of `gate_below`.
- R3: With `drive_cmd`=0 and `clamp_off`=0, `gate_below` (1 = gate below threshold) passes through a two-flop synchronizer and then the latch register. If `gate_below` rises between clock edges, `clamp_en` stays 0 after the first and second rising edges and is 1 after the third.
- R4: Once `clamp_en` is 1, it stays 1 for the rest of the off period, even after `gate_below` returns to 0.
- R5: When `drive_cmd` goes from 0 to 1, `clamp_en` drops to 0 in the same cycle. The latched state is also cleared, so a later off period with `gate_below`=0 keeps `clamp_en` at 0.
- R6: While `clamp_off`=1, `clamp_en` is 0 combinationally and the latched state is cleared. After `clamp_off` returns to 0, `clamp_en` stays 0 until a new below-threshold report arrives.
- R7: Each off period starts with the clamp open. A `gate_below`=1 seen while `drive_cmd`=1 does not close the clamp after the command falls, provided `gate_below` is 0 by then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| drive_cmd | input | 1 | Registered gate drive command, 1 = gate on |
| gate_below | input | 1 | Asynchronous comparator output, 1 = gate below clamp threshold |
| clamp_off | input | 1 | 1 = clamp unused, hold it open |
| clamp_en | output | 1 | 1 = close the clamp switch |

## Verification
The in-RTL assertions check, on every cycle, the state transitions of the latch. These are: it sets after a synchronized low report, it holds through the off period, it clears after the command is high or the clamp is disabled, and it is open at each falling command. The exact three-edge latency from an asynchronous `gate_below` change to `clamp_en`, and the combinational forcing low by `drive_cmd` and `clamp_off`, can only be shown by the bench scenarios. The same applies to ignoring below-threshold reports that arrive during the on phase.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int unsigned MC_SYNC_MIN = 2;

  // next value of the clamp latch
  function automatic logic clamp_next(input logic cur, input logic low_s,
                                      input logic cmd, input logic off);
    if (off || cmd) return 1'b0;
    return cur | low_s;
  endfunction
endpackage

// File: rtl/mc_sync.sv
module mc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] stg;

  generate
    if (STAGES < mc_pkg::MC_SYNC_MIN) begin : g_bad
      initial $error("mc_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], din};
  end

  assign dout = stg[LAST];

  AST_SYNC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout) |-> $past(stg[STAGES-2])); // R3
endmodule

// File: rtl/mc_latch.sv
module mc_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd,
  input  logic off,
  input  logic low_s,
  output logic clamp_q
);
  import mc_pkg::*;

  logic cmd_q;
  logic cmd_fall;
  logic cmd_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= 1'b0;
      clamp_q <= 1'b0;
    end else begin
      cmd_q   <= cmd;
      clamp_q <= clamp_next(clamp_q, low_s, cmd, off);
    end
  end

  assign cmd_fall = cmd_q & ~cmd;
  assign cmd_rise = ~cmd_q & cmd;

  AST_SET_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd && !off && low_s) |=> clamp_q); // R3
  AST_SET_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_q) |-> $past(low_s)); // R3
  AST_HOLD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_q && !cmd && !off) |=> clamp_q); // R4
  AST_RELEASE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rise |=> !clamp_q); // R5
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> !clamp_q); // R6
  AST_OPEN_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fall |-> !clamp_q); // R7
endmodule

// File: rtl/mc_clamp_ctrl.sv
module mc_clamp_ctrl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_cmd,
  input  logic gate_below,
  input  logic clamp_off,
  output logic clamp_en
);
  logic low_sync;
  logic clamp_state;

  mc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (gate_below),
    .dout (low_sync)
  );

  mc_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (drive_cmd),
    .off    (clamp_off),
    .low_s  (low_sync),
    .clamp_q(clamp_state)
  );

  assign clamp_en = clamp_state & ~drive_cmd & ~clamp_off;

  AST_RESET_OPEN: assert property (@(posedge clk)
    !rst_n |-> !clamp_state); // R1
endmodule

// File: tb/mc_clamp_ctrl_tb.sv
module mc_clamp_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drive_cmd = 1'b1;
  logic gate_below = 1'b0;
  logic clamp_off = 1'b0;
  logic clamp_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mc_clamp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .drive_cmd(drive_cmd),
    .gate_below(gate_below), .clamp_off(clamp_off), .clamp_en(clamp_en)
  );

  // reference model: history queue of sampled comparator values, one flag
  bit hist[$] = '{0, 0};
  bit held = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{0, 0};
      held = 0;
    end else begin
      if (drive_cmd || clamp_off) held = 0;
      else if (hist[0]) held = 1;
      void'(hist.pop_front());
      hist.push_back(gate_below);
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: clamp_en=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(posedge clk) begin
    #5;
    if (rst_n && !done)
      check("R2/R3/R4", clamp_en, held & ~drive_cmd & ~clamp_off);
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    step(2);
    check("R1", clamp_en, 1'b0);
    rst_n = 1'b1;
    step(2);
    check("R1", clamp_en, 1'b0);
    // R7: below-threshold report during on phase is ignored
    gate_below = 1'b1;
    step(4);
    check("R2", clamp_en, 1'b0);
    gate_below = 1'b0;
    step(3);
    drive_cmd = 1'b0;
    step(5);
    check("R7", clamp_en, 1'b0);
    // R3: latency of three edges
    gate_below = 1'b1;
    step(2);
    check("R3", clamp_en, 1'b0);
    step(1);
    check("R3", clamp_en, 1'b1);
    // R4: hold after the gate rises back
    gate_below = 1'b0;
    step(6);
    check("R4", clamp_en, 1'b1);
    // R5: release on rising command
    drive_cmd = 1'b1;
    #1;
    check("R5", clamp_en, 1'b0);
    step(3);
    drive_cmd = 1'b0;
    step(5);
    check("R5", clamp_en, 1'b0);
    // R2: command high with gate reported low
    gate_below = 1'b1;
    step(4);
    check("R3", clamp_en, 1'b1);
    drive_cmd = 1'b1;
    step(4);
    check("R2", clamp_en, 1'b0);
    // R6: disable
    drive_cmd = 1'b0;
    step(4);
    check("R3", clamp_en, 1'b1);
    clamp_off = 1'b1;
    #1;
    check("R6", clamp_en, 1'b0);
    step(4);
    check("R6", clamp_en, 1'b0);
    gate_below = 1'b0;
    step(3);
    clamp_off = 1'b0;
    step(4);
    check("R6", clamp_en, 1'b0);
    // R3: one-cycle pulse still captured, with pattern of toggles
    gate_below = 1'b1;
    step(1);
    gate_below = 1'b0;
    step(3);
    check("R3", clamp_en, 1'b1);
    // alternating pattern of commands with reset mid-run
    for (int k = 0; k < 20; k++) begin
      drive_cmd = k[0];
      gate_below = k[1] ^ k[2];
      step(2);
    end
    rst_n = 1'b0;
    step(1);
    check("R1", clamp_en, 1'b0);
    rst_n = 1'b1;
    drive_cmd = 1'b1;
    gate_below = 1'b0;
    step(3);
    finish_run();
  end
endmodule